// File: doc/BRIEF.md
# Audio Serial Bit and Frame Clock Generator

This block runs on an audio master clock and produces the two timing clocks of a stereo serial audio link: a bit clock and a left/right frame clock. The bit clock is the master clock slowed by one of two fixed ratios. The frame clock is derived from the bit clock by one of three fixed ratios, so the two clocks always stay phase-locked. Both outputs are registered in the master clock domain and keep a 50% duty cycle.

A small write-only configuration register holds an enable bit, a bit-clock ratio select and a frame-clock ratio select. One enable drives both outputs. When the enable is cleared, both clocks park low and every counter clears. When it is set again, a new frame starts in the left-channel phase. Ratio changes made while the block is running are held back until the current frame ends, so no frame is ever cut short.

Top module: `i2sclk_gen`

## Requirements
- R1: With the bit-ratio select at 0 the bit clock is high for 1 master cycle and low for 1 master cycle (master/2). With the select at 1 it is high for 2 cycles and low for 2 cycles (master/4).
- R2: The frame-ratio select picks the frame clock period in bit clocks: code 00 gives 32, code 01 gives 64 and code 10 gives 128. Each level of the frame clock lasts half that many bit-clock falling edges (16, 32 or 64).
- R3: Frame-ratio code 11 behaves exactly like code 10, with 64 falling edges per level.
- R4: While the block is running, the frame clock changes only in the master cycle in which the bit clock falls.
- R5: When the enable is cleared, both outputs are low no later than the second master clock edge after the write, and they stay low while the block is disabled.
- R6: After the block is enabled, the first bit-clock edge is a rising edge, and the frame clock stays low (left phase) for one full half-frame before it first rises.
- R7: A ratio written while the block is running takes effect at the next falling edge of the frame clock. Until then the current frame keeps running at the old bit-clock and frame ratios.
- R8: A write is accepted in the cycle where `cfg_wr` is high. Bit 0 of the data is the enable, bit 1 is the bit-ratio select and bits 3:2 are the frame-ratio code. After reset all fields are clear and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration data: enable, bit-ratio select, frame-ratio code |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Left/right frame clock |

## Verification
All eight combinations of bit-ratio select and frame-ratio code are applied directly, followed by random combinations. Each combination is started from the disabled state. This setup tells apart a wrong divide, a wrong cascade source and a mishandled unused code, because the count of falling edges per frame level and the length of each bit-clock level are measured on their own. A ratio change written partway through the left half shows whether the update waits for the frame boundary or takes effect at once. Disabling the block mid-frame and then enabling it again shows whether the outputs park low and whether a restart begins cleanly in the left phase.

// File: rtl/i2sclk_pkg.sv
package i2sclk_pkg;

    localparam int FSEL_W = 2;

    typedef struct packed {
        logic              en;
        logic              bsel;
        logic [FSEL_W-1:0] fsel;
    } clk_cfg_t;

    typedef struct packed {
        clk_cfg_t          pend;
        logic              bsel;
        logic [FSEL_W-1:0] fsel;
    } cfg_state_t;

endpackage

// File: rtl/i2sclk_cfg_reg.sv
module i2sclk_cfg_reg
    import i2sclk_pkg::*;
#(
    parameter int EN_POS   = 0,
    parameter int BSEL_POS = 1,
    parameter int FSEL_POS = 2,
    parameter int DW       = FSEL_POS + FSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              load_act,
    output logic              run,
    output logic              act_bsel,
    output logic [FSEL_W-1:0] act_fsel
);

    cfg_state_t st_d, st_q;
    clk_cfg_t   dec;
    clk_cfg_t   src;

    always_comb begin
        st_d     = st_q;
        dec.en   = wr_data[EN_POS];
        dec.bsel = wr_data[BSEL_POS];
        dec.fsel = wr_data[FSEL_POS +: FSEL_W];
        src      = wr_en ? dec : st_q.pend;
        if (wr_en) begin
            st_d.pend = dec;
        end
        if (load_act) begin
            st_d.bsel = src.bsel;
            st_d.fsel = src.fsel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run      = st_q.pend.en;
    assign act_bsel = st_q.bsel;
    assign act_fsel = st_q.fsel;

endmodule

// File: rtl/i2sclk_bit_div.sv
module i2sclk_bit_div #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bsel,
    output logic bclk,
    output logic fall_tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic             lvl;
    } bdiv_t;

    bdiv_t            bd_d, bd_q;
    logic [PRE_W-1:0] half_m1;
    logic             wrap;

    always_comb begin
        half_m1 = PRE_W'((32'd1 << bsel) - 32'd1);
        wrap    = (bd_q.cnt == half_m1);
        bd_d    = bd_q;
        if (!run) begin
            bd_d = '0;
        end else if (wrap) begin
            bd_d.cnt = '0;
            bd_d.lvl = ~bd_q.lvl;
        end else begin
            bd_d.cnt = bd_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bd_q <= '0;
        end else begin
            bd_q <= bd_d;
        end
    end

    assign bclk      = bd_q.lvl;
    assign fall_tick = run && wrap && bd_q.lvl;

endmodule

// File: rtl/i2sclk_frame_div.sv
module i2sclk_frame_div #(
    parameter int FSEL_W    = 2,
    parameter int HALF_BASE = 16,
    parameter int MAX_SHIFT = 2,
    parameter int CNT_W     = $clog2(HALF_BASE << MAX_SHIFT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fall_tick,
    input  logic [FSEL_W-1:0] fsel,
    output logic              lrclk,
    output logic              boundary
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
    } fdiv_t;

    fdiv_t            fd_d, fd_q;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;
    int               shift;

    always_comb begin
        shift   = (int'(fsel) > MAX_SHIFT) ? MAX_SHIFT : int'(fsel);
        half_m1 = CNT_W'((HALF_BASE << shift) - 1);
        wrap    = (fd_q.cnt == half_m1);
        fd_d    = fd_q;
        if (!run) begin
            fd_d = '0;
        end else if (fall_tick) begin
            if (wrap) begin
                fd_d.cnt = '0;
                fd_d.lvl = ~fd_q.lvl;
            end else begin
                fd_d.cnt = fd_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fd_q <= '0;
        end else begin
            fd_q <= fd_d;
        end
    end

    assign lrclk    = fd_q.lvl;
    assign boundary = fall_tick && wrap && fd_q.lvl;

endmodule

// File: rtl/i2sclk_gen.sv
module i2sclk_gen
    import i2sclk_pkg::*;
#(
    parameter int EN_POS    = 0,
    parameter int BSEL_POS  = 1,
    parameter int FSEL_POS  = 2,
    parameter int HALF_BASE = 16,
    parameter int MAX_SHIFT = 2,
    parameter int PRE_W     = 2,
    parameter int DW        = FSEL_POS + FSEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          bclk,
    output logic          lrclk
);

    logic              run;
    logic              act_bsel;
    logic [FSEL_W-1:0] act_fsel;
    logic              fall_tick;
    logic              boundary;
    logic              load_act;

    assign load_act = !run || boundary;

    i2sclk_cfg_reg #(
        .EN_POS  (EN_POS),
        .BSEL_POS(BSEL_POS),
        .FSEL_POS(FSEL_POS),
        .DW      (DW)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .load_act(load_act),
        .run     (run),
        .act_bsel(act_bsel),
        .act_fsel(act_fsel)
    );

    i2sclk_bit_div #(
        .PRE_W(PRE_W)
    ) u_bdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .bsel     (act_bsel),
        .bclk     (bclk),
        .fall_tick(fall_tick)
    );

    i2sclk_frame_div #(
        .FSEL_W   (FSEL_W),
        .HALF_BASE(HALF_BASE),
        .MAX_SHIFT(MAX_SHIFT)
    ) u_fdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .fall_tick(fall_tick),
        .fsel     (act_fsel),
        .lrclk    (lrclk),
        .boundary (boundary)
    );

endmodule

// File: rtl/i2sclk_gen_chk.sv
module i2sclk_gen_chk #(
    parameter int FSEL_W    = 2,
    parameter int HALF_BASE = 16,
    parameter int MAX_SHIFT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              bclk,
    input logic              lrclk,
    input logic              act_bsel,
    input logic [FSEL_W-1:0] act_fsel
);

    logic       prev_b;
    logic       prev_l;
    logic [7:0] fcnt;

    function automatic int half_len(input logic [FSEL_W-1:0] f);
        int s;
        s = (int'(f) > MAX_SHIFT) ? MAX_SHIFT : int'(f);
        return HALF_BASE << s;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_b <= 1'b0;
            prev_l <= 1'b0;
            fcnt   <= '0;
        end else begin
            prev_b <= bclk;
            prev_l <= lrclk;
            if (!run || (prev_l != lrclk)) begin
                fcnt <= '0;
            end else if (prev_b && !bclk) begin
                fcnt <= fcnt + 8'd1;
            end
        end
    end

    // R1: at the fastest ratio the bit clock flips every master cycle
    p_bclk_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !act_bsel && !$past(act_bsel)) |-> (bclk != $past(bclk)));

    // R2, R3: every frame clock level spans the selected count of falling edges
    p_half_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (prev_l != lrclk)) |-> ((int'(fcnt) + 1) == half_len($past(act_fsel))));

    // R4: frame clock moves only together with a bit clock fall
    p_lr_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$stable(lrclk)) |-> $fell(bclk));

    // R5: outputs parked low once disabled
    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> (!bclk && !lrclk));

    // R6: a restart begins in the left phase
    p_left_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(run, 2)) |-> !lrclk);

endmodule

bind i2sclk_gen i2sclk_gen_chk #(
    .FSEL_W   (i2sclk_pkg::FSEL_W),
    .HALF_BASE(HALF_BASE),
    .MAX_SHIFT(MAX_SHIFT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .bclk    (bclk),
    .lrclk   (lrclk),
    .act_bsel(act_bsel),
    .act_fsel(act_fsel)
);

// File: tb/i2sclk_gen_bench.sv
module i2sclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic       bclk;
    logic       lrclk;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    i2sclk_gen u_i2sclk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .bclk     (bclk),
        .lrclk    (lrclk)
    );

    function automatic int exp_bhalf(input logic bs);
        return bs ? 2 : 1;
    endfunction

    function automatic int exp_lhalf(input logic [1:0] fs);
        case (fs)
            2'b00:   return 16;
            2'b01:   return 32;
            default: return 64;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic bs, input logic [1:0] fs);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = {fs, bs, en};
        @(negedge clk);
        cfg_wr    = 1'b0;
        cfg_wdata = 4'($urandom);
    endtask

    // Waits for the next frame clock change; counts bit clock falls and
    // bit clock levels whose length differs from bh (first level skipped).
    task automatic meas_half(input int bh, output int falls, output int bad_runs,
                             output int bad_align);
        logic pb, pl;
        int   run_len;
        int   nruns;
        pb = bclk; pl = lrclk;
        falls = 0; bad_runs = 0; bad_align = 0; run_len = 0; nruns = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            run_len++;
            if (bclk != pb) begin
                if (nruns > 0 && run_len != bh) bad_runs++;
                nruns++;
                run_len = 0;
                if (pb && !bclk) falls++;
            end
            if (lrclk != pl) begin
                if (!(pb && !bclk)) bad_align++;
                break;
            end
            pb = bclk;
        end
    endtask

    task automatic run_combo(input logic bs, input logic [1:0] fs);
        int f, br, ba, f2, br2, ba2;
        write_cfg(1'b0, ~bs, ~fs);
        repeat (5) @(negedge clk);
        write_cfg(1'b1, bs, fs);
        check(lrclk == 1'b0, "R6 left phase at start", lrclk, 0);
        meas_half(exp_bhalf(bs), f, br, ba);
        check(f == exp_lhalf(fs), (fs == 2'b11) ? "R3 first half length" : "R2 first half length",
              f, exp_lhalf(fs));
        check(lrclk == 1'b1, "R6 first change is a rise", lrclk, 1);
        meas_half(exp_bhalf(bs), f2, br2, ba2);
        check(f2 == exp_lhalf(fs), (fs == 2'b11) ? "R3 second half length" : "R2 second half length",
              f2, exp_lhalf(fs));
        check(br + br2 == 0, "R1 bit clock level length", br + br2, 0);
        check(ba + ba2 == 0, "R4 frame edge on bit fall", ba + ba2, 0);
    endtask

    initial begin
        void'($urandom(32'd7351));
        #1500000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int f, br, ba, hi;
        repeat (4) @(negedge clk);
        check(bclk == 1'b0, "R8 bclk low in reset", bclk, 0);
        check(lrclk == 1'b0, "R8 lrclk low in reset", lrclk, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(bclk == 1'b0 && lrclk == 1'b0, "R8 idle after reset", bclk | lrclk, 0);

        // directed: every select combination
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 4; s++) begin
                run_combo(b[0], s[1:0]);
            end
        end
        // random combinations
        for (int k = 0; k < 6; k++) begin
            run_combo(1'($urandom), 2'($urandom));
        end

        // R5: disable mid-frame
        write_cfg(1'b1, 1'b1, 2'b01);
        repeat (300) @(negedge clk);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 4'b0110;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        check(bclk == 1'b0 && lrclk == 1'b0, "R5 low after disable", bclk | lrclk, 0);
        hi = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (bclk || lrclk) hi++;
        end
        check(hi == 0, "R5 stays low while disabled", hi, 0);

        // R6: re-enable, first bit clock edge rises
        write_cfg(1'b1, 1'b1, 2'b00);
        hi = 0;
        for (int i = 0; i < 4 && !bclk; i++) @(negedge clk);
        check(bclk == 1'b1 && lrclk == 1'b0, "R6 first bit edge rising", bclk, 1);

        // R7: ratio change mid-frame
        write_cfg(1'b0, 1'b0, 2'b00);
        write_cfg(1'b1, 1'b0, 2'b00);
        repeat (7) @(negedge clk);
        write_cfg(1'b1, 1'b1, 2'b01);
        meas_half(1, f, br, ba);
        meas_half(1, f, br, ba);
        check(f == 16, "R7 old frame ratio kept", f, 16);
        check(br == 0, "R7 old bit ratio kept", br, 0);
        check(lrclk == 1'b0, "R7 change at frame fall", lrclk, 0);
        meas_half(2, f, br, ba);
        check(f == 32, "R7 new frame ratio applied", f, 32);
        check(br == 0, "R7 new bit ratio applied", br, 0);
        check(ba == 0, "R4 alignment across change", ba, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule